// File: doc/BRIEF.md
# Video Timing Event Status Flags

This block records video timing events for a display controller in three sticky flags. Pulses mark vertical blanking, horizontal blanking and the start of display. A per-line strobe drives a raster counter. That counter sets its flag once a programmed number of lines has passed after a display start.

Each flag stays set until software clears it. Software can clear every flag at once through a global display reset, or clear one flag through its own one-cycle clear strobe. Software cannot set a flag directly.

The flags appear at fixed positions in a read-only status word. An interrupt request is raised when any set flag has its enable input high.

Top module: `vtev_status`

## Requirements
- R1: After reset the status word and the interrupt output are zero. The vertical blanking flag sits at status bit 11, the raster flag at bit 9 and the horizontal blanking flag at bit 8.
- R2: Status bits 13:12, bit 10 and bits 7:0 (and any bits above 13) always read zero.
- R3: A vertical blanking pulse sets the vertical blanking flag, visible on the status word one cycle later. The flag then holds until it is cleared.
- R4: A horizontal blanking pulse sets the horizontal blanking flag, visible one cycle later. The flag then holds until it is cleared.
- R5: After the raster flag is cleared, line strobes are ignored until the next display start. After that display start, the flag sets in the cycle following the N-th line strobe, where N is the offset input. With an offset of zero, the flag sets in the cycle following the display start itself.
- R6: A display start that arrives before the offset is reached restarts the line count from zero. Once the flag is set, further strobes and display starts leave it set until it is cleared.
- R7: The global display reset clears all three flags. Each per-flag clear clears only its own flag.
- R8: A clear that arrives in the same cycle as the setting event wins, so the flag reads zero afterwards.
- R9: A clear acts only in the cycle it is high. An event in the following cycle sets the flag again.
- R10: The interrupt output is registered. It equals the OR of each flag ANDed with its enable (enable bit 0 for horizontal blanking, bit 1 for raster, bit 2 for vertical blanking), one cycle after the flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_pulse | input | 1 | Vertical blanking event |
| hblank_pulse | input | 1 | Horizontal blanking event |
| disp_start_pulse | input | 1 | Display start event |
| line_strobe | input | 1 | One pulse per raster line |
| raster_ofs | input | LINE_W | Line offset for the raster flag |
| disp_reset | input | 1 | Global clear of all flags |
| clr_vb | input | 1 | Clear vertical blanking flag |
| clr_ras | input | 1 | Clear raster flag |
| clr_hb | input | 1 | Clear horizontal blanking flag |
| irq_en | input | 3 | Per-flag interrupt enables {vb, raster, hb} |
| status_word | output | STAT_W | Read-only status word |
| irq | output | 1 | Interrupt request |

## Verification
Each flag is registered once, so the bench drives an event for one cycle and reads the status word just after the next rising edge. The interrupt passes through one more register, so it is read one edge later than the flags. The check taken at the earlier edge confirms that it is still low. For the raster flag, the bench sweeps the offset from zero to nine and reads the status word after every strobe. The flag must stay low until the strobe whose count equals the offset, and must be high from the edge that follows it. All inputs change 1 ns after a rising edge, and all samples are taken in the same place.

// File: rtl/vtev_pkg.sv
package vtev_pkg;
  localparam int NFLAG  = 3;
  localparam int FL_HB  = 0;
  localparam int FL_RAS = 1;
  localparam int FL_VB  = 2;

  // status-word bit position of each flag
  function automatic int flag_pos(input int idx);
    case (idx)
      FL_HB:   return 8;
      FL_RAS:  return 9;
      default: return 11;
    endcase
  endfunction

  typedef enum logic [1:0] {
    RS_ARMED = 2'd0,
    RS_COUNT = 2'd1,
    RS_DONE  = 2'd2
  } ras_st_e;
endpackage

// File: rtl/vtev_sticky_flag.sv
module vtev_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !flag_o);
  a_r3_set_visible: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> flag_o);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/vtev_raster_counter.sv
module vtev_raster_counter
  import vtev_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              disp_start_i,
  input  logic              strobe_i,
  input  logic [LINE_W-1:0] ofs_i,
  output logic              hit_o
);
  localparam int CW = LINE_W + 1;

  ras_st_e           st_q, st_n;
  logic [LINE_W-1:0] cnt_q, cnt_n;
  logic [CW-1:0]     cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    hit_o = 1'b0;
    if (clr_i) begin
      st_n  = RS_ARMED;
      cnt_n = '0;
    end else begin
      case (st_q)
        RS_ARMED, RS_COUNT: begin
          if (disp_start_i) begin
            cnt_n = '0;
            if (ofs_i == '0) begin
              hit_o = 1'b1;
              st_n  = RS_DONE;
            end else begin
              st_n = RS_COUNT;
            end
          end else if (st_q == RS_COUNT && strobe_i) begin
            if (cnt_inc >= {1'b0, ofs_i}) begin
              hit_o = 1'b1;
              st_n  = RS_DONE;
            end else begin
              cnt_n = cnt_inc[LINE_W-1:0];
            end
          end
        end
        default: ;  // saturated until cleared
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= RS_ARMED;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  a_r6_saturated_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == RS_DONE && !clr_i) |=> (st_q == RS_DONE));
  a_r5_armed_ignores_lines: assert property (@(posedge clk) disable iff (rst)
    (st_q == RS_ARMED && !disp_start_i) |-> !hit_o);
  a_r7_clear_rearms: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (st_q == RS_ARMED));
endmodule

// File: rtl/vtev_irq_reg.sv
module vtev_irq_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_i & en_i);
  end
endmodule

// File: rtl/vtev_status.sv
module vtev_status
  import vtev_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank_pulse,
  input  logic              hblank_pulse,
  input  logic              disp_start_pulse,
  input  logic              line_strobe,
  input  logic [LINE_W-1:0] raster_ofs,
  input  logic              disp_reset,
  input  logic              clr_vb,
  input  logic              clr_ras,
  input  logic              clr_hb,
  input  logic [NFLAG-1:0]  irq_en,
  output logic [STAT_W-1:0] status_word,
  output logic              irq
);
  logic [NFLAG-1:0] set_v, clr_v, flag_q;
  logic             ras_hit;

  assign clr_v[FL_HB]  = disp_reset | clr_hb;
  assign clr_v[FL_RAS] = disp_reset | clr_ras;
  assign clr_v[FL_VB]  = disp_reset | clr_vb;
  assign set_v[FL_HB]  = hblank_pulse;
  assign set_v[FL_RAS] = ras_hit;
  assign set_v[FL_VB]  = vblank_pulse;

  vtev_raster_counter #(.LINE_W(LINE_W)) ras_i (
    .clk(clk), .rst(rst), .clr_i(clr_v[FL_RAS]),
    .disp_start_i(disp_start_pulse), .strobe_i(line_strobe),
    .ofs_i(raster_ofs), .hit_o(ras_hit)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    vtev_sticky_flag flag_i (
      .clk(clk), .rst(rst), .set_i(set_v[g]), .clr_i(clr_v[g]),
      .flag_o(flag_q[g])
    );
  end

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NFLAG; i++) status_word[flag_pos(i)] = flag_q[i];
  end

  vtev_irq_reg #(.N(NFLAG)) irq_i (
    .clk(clk), .rst(rst), .flags_i(flag_q), .en_i(irq_en), .irq_o(irq)
  );

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(status_word != '0));
  a_r7_global_clear: assert property (@(posedge clk) disable iff (rst)
    disp_reset |=> (status_word == '0));
endmodule

// File: tb/vtev_status_tb_top.sv
module vtev_status_tb_top;
  localparam int LW = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vb = 0, hb = 0, ds = 0, ls = 0, dr = 0, cvb = 0, cras = 0, chb = 0;
  logic [LW-1:0] ofs = '0;
  logic [2:0] en = '0;
  logic [15:0] stat;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vtev_status #(.LINE_W(LW), .STAT_W(16)) dut_i (
    .clk(clk), .rst(rst), .vblank_pulse(vb), .hblank_pulse(hb),
    .disp_start_pulse(ds), .line_strobe(ls), .raster_ofs(ofs),
    .disp_reset(dr), .clr_vb(cvb), .clr_ras(cras), .clr_hb(chb),
    .irq_en(en), .status_word(stat), .irq(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic gclear();
    dr = 1; tick(); dr = 0;
  endtask

  function automatic logic [15:0] smap(input logic v, input logic r, input logic h);
    return (16'(v) << 11) | (16'(r) << 9) | (16'(h) << 8);
  endfunction

  initial begin
    repeat (3) tick();
    rst = 0;
    chk("R1 reset status", 32'(stat), 0);
    chk("R1 reset irq", 32'(irq), 0);

    // R3/R4/R2: all vb/hb combinations, then hold
    for (int m = 0; m < 4; m++) begin
      gclear();
      vb = m[1]; hb = m[0]; tick(); vb = 0; hb = 0;
      chk("R3/R4 set", 32'(stat), 32'(smap(m[1], 0, m[0])));
      chk("R2 reserved zero", 32'(stat & 16'hF4FF), 0);
      repeat (3) tick();
      chk("R3 R4 hold", 32'(stat), 32'(smap(m[1], 0, m[0])));
    end

    // R7 per-flag and global clears
    ofs = 0; gclear();
    vb = 1; hb = 1; ds = 1; tick(); vb = 0; hb = 0; ds = 0;
    chk("R1 R5 all set positions", 32'(stat), 32'h0B00);
    chk("R2 reserved zero all set", 32'(stat & 16'hF4FF), 0);
    chb = 1; tick(); chb = 0;
    chk("R7 clr hb only", 32'(stat), 32'h0A00);
    cras = 1; tick(); cras = 0;
    chk("R7 clr raster only", 32'(stat), 32'h0800);
    cvb = 1; tick(); cvb = 0;
    chk("R7 clr vb only", 32'(stat), 32'h0000);
    vb = 1; hb = 1; ds = 1; tick(); vb = 0; hb = 0; ds = 0;
    gclear();
    chk("R7 global clear", 32'(stat), 0);

    // R8 clear beats simultaneous set
    vb = 1; cvb = 1; tick(); vb = 0; cvb = 0;
    chk("R8 vb clear wins", 32'(stat), 0);
    hb = 1; dr = 1; tick(); hb = 0; dr = 0;
    chk("R8 hb global clear wins", 32'(stat), 0);
    ds = 1; cras = 1; tick(); ds = 0; cras = 0;
    chk("R8 raster clear wins", 32'(stat), 0);

    // R9 clear is a one-cycle pulse
    cvb = 1; tick(); cvb = 0; vb = 1; tick(); vb = 0;
    chk("R9 set after clear", 32'(stat), 32'h0800);
    chb = 1; tick(); chb = 0; hb = 1; tick(); hb = 0;
    chk("R9 hb set after clear", 32'(stat), 32'h0900);
    gclear();

    // R5 offset sweep
    for (int o = 0; o < 10; o++) begin
      ofs = LW'(o); gclear();
      ls = 1; repeat (o + 2) tick(); ls = 0;
      chk("R5 lines ignored before display start", 32'(stat[9]), 0);
      ds = 1; tick(); ds = 0;
      chk("R5 after display start", 32'(stat[9]), 32'(o == 0));
      for (int k = 1; k <= o; k++) begin
        ls = 1; tick(); ls = 0;
        chk("R5 line count", 32'(stat[9]), 32'(k >= o));
        tick();
      end
    end

    // R6 restart and hold
    ofs = 3; gclear();
    ds = 1; tick(); ds = 0;
    ls = 1; repeat (2) tick(); ls = 0;
    ds = 1; tick(); ds = 0;
    ls = 1; repeat (2) tick(); ls = 0;
    chk("R6 restart on display start", 32'(stat[9]), 0);
    ls = 1; tick(); ls = 0;
    chk("R6 reached after restart", 32'(stat[9]), 1);
    ds = 1; tick(); ds = 0; ls = 1; repeat (5) tick(); ls = 0;
    chk("R6 stays set", 32'(stat[9]), 1);

    // R10 irq sweep over flags x enables
    ofs = 0;
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        en = 3'(e); gclear();
        tick();
        hb = f[0]; ds = f[1]; vb = f[2]; tick(); hb = 0; ds = 0; vb = 0;
        chk("R10 irq latency", 32'(irq), 0);
        tick();
        chk("R10 irq value", 32'(irq), 32'(|(3'(f) & 3'(e))));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule